// File: doc/BRIEF.md
# System Reset Generator with Watchdog and Clock Monitor

This block drives the system reset from three causes: the external or power-on reset pin, a watchdog timer that software must service, and a clock monitor that notices when the system clock has become slow or has stopped. It also reports on a small cause output which of the three started the most recent reset, so that the processor can fetch the matching reset vector.

The watchdog counts system clock cycles. A two-bit rate input selects its timeout, and software restarts it by writing an arming byte and then a confirming byte to a service port. The clock monitor runs from an independent slow reference clock. It exchanges a handshake token with the system clock domain and raises a failure when the token has not come back for a number of reference ticks. The stop-mode input freezes the system-domain side of that handshake, just as stop mode freezes the real clock. With the monitor enabled, entering stop mode therefore causes a clock-monitor reset. Every reset is stretched to a fixed number of system clock cycles.

Top module: `reset_gen`

## Requirements
- R1: While `porN` is low, `sysRst` is 1 and `rstCause` is 2'b00 (external/power-on), with no clock edge needed.
- R2: After `porN` rises, and after each watchdog or clock-monitor reset event, `sysRst` stays 1 for exactly HOLD_CYCLES system clock cycles and then falls.
- R3: With no valid service, the watchdog fires 2^(BASE_LOG2 + 2*optRate) cycles after reset release or after the last restart. Codes 0, 1, 2 and 3 give 2^BASE_LOG2, 4x, 16x and 64x that length.
- R4: A write of 8'h55 arms the service sequence, and a following write of 8'hAA restarts the watchdog. Idle cycles between the two writes are allowed. Any other written value clears the arming, and 8'hAA without arming does nothing. A restart in the same cycle as the timeout does not prevent the reset.
- R5: A watchdog reset sets `rstCause` to 2'b10.
- R6: With `optCme` at 1, a system clock that shows no activity for MON_TICKS reference ticks (including activity frozen by `stopMode`) causes a reset with `rstCause` 2'b01.
- R7: With `optCme` at 0, absence of the clock causes no reset. With `optCme` at 1 and the clock running, the monitor causes no reset.
- R8: Causes are ranked external above clock monitor, and clock monitor above watchdog. When causes coincide, `rstCause` shows the higher-ranked one.
- R9: `rstCause` keeps its value after reset ends until the next reset event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| refClk | input | 1 | Independent slow reference clock for the monitor |
| porN | input | 1 | External/power-on reset, active low, asynchronous |
| optRate | input | 2 | Watchdog timeout rate code |
| optCme | input | 1 | Clock monitor enable |
| svcWe | input | 1 | Service register write strobe |
| svcData | input | 8 | Service register write data |
| stopMode | input | 1 | Stop mode: freezes system clock activity |
| sysRst | output | 1 | System reset, active high |
| rstCause | output | 2 | Cause of the last reset: 00 external, 01 clock monitor, 10 watchdog |

## Verification
The assertions check on every cycle four things. A monitor failure wins over a simultaneous watchdog expiry. A watchdog expiry loads the watchdog cause. The stretched reset only ends when its count has finished. The cause register holds steady between events. In the reference domain they also check that a disabled monitor never reports failure. The exact timeout length for each rate code, the effect of broken and interleaved service sequences, and the stop-mode clock-monitor reset with its detection window can only be shown by the bench scenarios. The same holds for the ranking of the external reset over a failing monitor.

// File: rtl/reset_gen_pkg.sv
package reset_gen_pkg;
  typedef enum logic [1:0] {
    CAUSE_EXT    = 2'b00,
    CAUSE_CLKMON = 2'b01,
    CAUSE_COP    = 2'b10
  } cause_e;

  // control -> watchdog datapath strobes
  typedef struct packed {
    logic copClear;
    logic copRun;
  } copStrobe_t;

  localparam logic [7:0] SVC_ARM  = 8'h55;
  localparam logic [7:0] SVC_FIRE = 8'hAA;
endpackage

// File: rtl/reset_gen_cop.sv
module reset_gen_cop
  import reset_gen_pkg::*;
#(
  parameter int BASE_LOG2 = 15
) (
  input  logic       clk,
  input  logic       porN,
  input  logic [1:0] rate,
  input  copStrobe_t copStrb,
  output logic       copExpire
);
  localparam int MAXLOG = BASE_LOG2 + 6;

  logic [MAXLOG-1:0] copCnt;
  logic [MAXLOG-1:0] lastCount;
  logic [2:0]        shAmt;

  // all ones shifted down gives 2^(BASE_LOG2 + 2*rate) - 1
  always_comb begin
    shAmt     = 3'd6 - {rate, 1'b0};
    lastCount = {MAXLOG{1'b1}} >> shAmt;
  end

  assign copExpire = copStrb.copRun && (copCnt >= lastCount);

  always_ff @(posedge clk or negedge porN) begin
    if (!porN)                 copCnt <= '0;
    else if (copStrb.copClear) copCnt <= '0;
    else if (copStrb.copRun)   copCnt <= copExpire ? '0 : copCnt + 1'b1;
  end

  // R3
  cop_restart_chk: assert property (@(posedge clk) disable iff (!porN)
    copStrb.copClear |=> (copCnt == '0));
endmodule

// File: rtl/reset_gen_clkmon.sv
module reset_gen_clkmon #(
  parameter int MON_TICKS = 4
) (
  input  logic clk,
  input  logic refClk,
  input  logic porN,
  input  logic cme,
  input  logic stopMode,
  output logic monFailSys
);
  localparam int SW = $clog2(MON_TICKS + 1);
  localparam logic [SW-1:0] STALE_MAX = SW'(MON_TICKS);

  logic tokReq, reqS1, reqS2, tokAck, ackS1, ackS2;
  logic [SW-1:0] staleCnt;
  logic monFailQ, failS1, failS2;

  // system side: echo the token only while the clock is active
  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      reqS1 <= 1'b0; reqS2 <= 1'b0; tokAck <= 1'b0;
      failS1 <= 1'b0; failS2 <= 1'b0;
    end else begin
      reqS1  <= tokReq;
      reqS2  <= reqS1;
      if (!stopMode) tokAck <= reqS2;
      failS1 <= monFailQ;
      failS2 <= failS1;
    end
  end

  // reference side: issue token, count ticks without a reply
  always_ff @(posedge refClk or negedge porN) begin
    if (!porN) begin
      ackS1 <= 1'b0; ackS2 <= 1'b0; tokReq <= 1'b0;
      staleCnt <= '0; monFailQ <= 1'b0;
    end else begin
      ackS1 <= tokAck;
      ackS2 <= ackS1;
      if (ackS2 == tokReq) begin
        tokReq   <= ~tokReq;
        staleCnt <= '0;
      end else if (!cme) begin
        staleCnt <= '0;
      end else if (staleCnt < STALE_MAX) begin
        staleCnt <= staleCnt + 1'b1;
      end
      monFailQ <= cme && (staleCnt >= STALE_MAX);
    end
  end

  assign monFailSys = failS2;

  // R7
  mon_off_chk: assert property (@(posedge refClk) disable iff (!porN)
    !cme |=> !monFailQ);
endmodule

// File: rtl/reset_gen_ctrl.sv
module reset_gen_ctrl
  import reset_gen_pkg::*;
#(
  parameter int HOLD_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       porN,
  input  logic       monFail,
  input  logic       copExpire,
  input  logic       svcWe,
  input  logic [7:0] svcData,
  output copStrobe_t copStrb,
  output logic       sysRst,
  output cause_e     rstCause
);
  localparam int HW = (HOLD_CYCLES > 1) ? $clog2(HOLD_CYCLES) : 1;
  localparam logic [HW-1:0] HOLD_LAST = HW'(HOLD_CYCLES - 1);

  logic          rstActive, monFailD, armed;
  logic [HW-1:0] holdCnt;
  logic          monRise, svcFire;

  assign monRise = monFail && !monFailD;
  assign svcFire = svcWe && (svcData == SVC_FIRE) && armed;

  always_comb begin
    copStrb.copRun   = !rstActive;
    copStrb.copClear = rstActive || svcFire;
  end

  always_ff @(posedge clk or negedge porN) begin
    if (!porN) begin
      rstActive <= 1'b1;
      holdCnt   <= '0;
      rstCause  <= CAUSE_EXT;
      armed     <= 1'b0;
      monFailD  <= 1'b0;
    end else begin
      monFailD <= monFail;
      if (monRise || copExpire) begin
        rstActive <= 1'b1;
        holdCnt   <= '0;
        rstCause  <= monRise ? CAUSE_CLKMON : CAUSE_COP;
      end else if (rstActive) begin
        if (holdCnt == HOLD_LAST) rstActive <= 1'b0;
        else                      holdCnt   <= holdCnt + 1'b1;
      end
      if (rstActive)  armed <= 1'b0;
      else if (svcWe) armed <= (svcData == SVC_ARM);
    end
  end

  assign sysRst = rstActive;

  // R8
  prio_chk: assert property (@(posedge clk) disable iff (!porN)
    (monFail && !monFailD && copExpire) |=> (rstCause == CAUSE_CLKMON));
  // R5
  cop_cause_chk: assert property (@(posedge clk) disable iff (!porN)
    (copExpire && !(monFail && !monFailD)) |=> (rstActive && rstCause == CAUSE_COP));
  // R2
  hold_len_chk: assert property (@(posedge clk) disable iff (!porN)
    $fell(rstActive) |-> ($past(holdCnt) == HOLD_LAST));
  // R9
  cause_hold_chk: assert property (@(posedge clk) disable iff (!porN)
    (!copExpire && !(monFail && !monFailD)) |=> $stable(rstCause));
endmodule

// File: rtl/reset_gen.sv
module reset_gen
  import reset_gen_pkg::*;
#(
  parameter int BASE_LOG2   = 15,
  parameter int HOLD_CYCLES = 4096,
  parameter int MON_TICKS   = 4
) (
  input  logic       clk,
  input  logic       refClk,
  input  logic       porN,
  input  logic [1:0] optRate,
  input  logic       optCme,
  input  logic       svcWe,
  input  logic [7:0] svcData,
  input  logic       stopMode,
  output logic       sysRst,
  output logic [1:0] rstCause
);
  copStrobe_t copStrb;
  logic       copExpire, monFail;
  cause_e     causeQ;

  reset_gen_ctrl #(.HOLD_CYCLES(HOLD_CYCLES)) ctrl_i (
    .clk(clk), .porN(porN), .monFail(monFail), .copExpire(copExpire),
    .svcWe(svcWe), .svcData(svcData), .copStrb(copStrb),
    .sysRst(sysRst), .rstCause(causeQ)
  );

  reset_gen_cop #(.BASE_LOG2(BASE_LOG2)) cop_i (
    .clk(clk), .porN(porN), .rate(optRate), .copStrb(copStrb),
    .copExpire(copExpire)
  );

  reset_gen_clkmon #(.MON_TICKS(MON_TICKS)) mon_i (
    .clk(clk), .refClk(refClk), .porN(porN), .cme(optCme),
    .stopMode(stopMode), .monFailSys(monFail)
  );

  assign rstCause = causeQ;
endmodule

// File: tb/reset_gen_tb_top.sv
`timescale 1ns/1ps
module reset_gen_tb_top;
  localparam int BASE = 6;
  localparam int HOLD = 32;
  localparam int TICKS = 4;

  logic clk = 1'b0, refClk = 1'b0;
  logic porN, optCme, svcWe, stopMode;
  logic [1:0] optRate;
  logic [7:0] svcData;
  logic sysRst;
  logic [1:0] rstCause;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;
  always #50  refClk = ~refClk;

  reset_gen #(.BASE_LOG2(BASE), .HOLD_CYCLES(HOLD), .MON_TICKS(TICKS)) dut_i (
    .clk(clk), .refClk(refClk), .porN(porN), .optRate(optRate),
    .optCme(optCme), .svcWe(svcWe), .svcData(svcData),
    .stopMode(stopMode), .sysRst(sysRst), .rstCause(rstCause)
  );

  function automatic int limitOf(input int r);
    return 1 << (BASE + 2 * r);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic waitHold(output int n);
    n = 0;
    while (sysRst && n < 100000) begin n++; @(negedge clk); end
  endtask

  task automatic countLow(output int n);
    n = 0;
    while (!sysRst && n < 10000) begin n++; @(negedge clk); end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    svcWe = 1'b1; svcData = d;
    @(negedge clk);
    svcWe = 1'b0;
  endtask

  initial begin
    repeat (250000) @(posedge clk);
    check(1'b0, "watchdog timeout", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    int n, seed;
    bit bad;
    seed = $urandom(32'd2024);
    porN = 1'b0; optCme = 1'b0; svcWe = 1'b0; stopMode = 1'b0;
    optRate = 2'd0; svcData = 8'h00;
    idle(3);
    check(sysRst == 1'b1, "R1 reset asserted", sysRst, 1);
    check(rstCause == 2'b00, "R1 cause external", rstCause, 0);
    porN = 1'b1;
    waitHold(n);
    check(n == HOLD, "R2 hold after release", n, HOLD);
    countLow(n);
    check(n == limitOf(0), "R3 rate 0 timeout", n, limitOf(0));
    check(rstCause == 2'b10, "R5 watchdog cause", rstCause, 2);
    for (int r = 1; r < 4; r++) begin
      optRate = 2'(r);
      waitHold(n);
      check(n == HOLD, "R2 hold after watchdog", n, HOLD);
      countLow(n);
      check(n == limitOf(r), "R3 rate timeout", n, limitOf(r));
    end
    optRate = 2'd0;
    // proper sequence with idle gap
    waitHold(n);
    idle(10); wr(8'h55); idle(3); wr(8'hAA);
    countLow(n);
    check(n == limitOf(0), "R4 valid service restart", n, limitOf(0));
    // broken sequence
    waitHold(n);
    wr(8'h55); wr(8'h12); wr(8'hAA);
    countLow(n);
    check(n + 3 == limitOf(0), "R4 broken sequence ignored", n + 3, limitOf(0));
    // unarmed confirm
    waitHold(n);
    wr(8'hAA);
    countLow(n);
    check(n + 1 == limitOf(0), "R4 unarmed confirm ignored", n + 1, limitOf(0));

    // random service rounds against a bench model
    for (int rd = 0; rd < 8; rd++) begin
      int r, lim, rem, budget, pick;
      bit armedM, we;
      logic [7:0] d;
      r = $urandom_range(0, 2);
      optRate = 2'(r);
      waitHold(n);
      check(n == HOLD, "R2 hold random round", n, HOLD);
      lim = limitOf(r); rem = lim; armedM = 1'b0; bad = 1'b0;
      budget = $urandom_range(2, 6);
      while (rem > 0) begin
        if (sysRst) bad = 1'b1;
        we = 1'b0; d = 8'h00;
        if (budget > 0 && $urandom_range(0, lim / 16) == 0) begin
          budget--; we = 1'b1;
          pick = $urandom_range(0, 9);
          d = (pick < 4) ? 8'h55 : (pick < 8) ? 8'hAA : 8'($urandom_range(0, 255));
        end
        svcWe = we; svcData = d;
        @(negedge clk);
        if (rem == 1) rem = 0;
        else if (we && d == 8'hAA && armedM) rem = lim;
        else rem--;
        if (we) armedM = (d == 8'h55);
      end
      svcWe = 1'b0;
      check(!bad && sysRst, "R4 R3 random service round", sysRst, 1);
      check(rstCause == 2'b10, "R5 random round cause", rstCause, 2);
    end

    // clock monitor
    optRate = 2'd3;
    waitHold(n);
    optCme = 1'b0; stopMode = 1'b1; bad = 1'b0;
    repeat (600) begin if (sysRst) bad = 1'b1; @(negedge clk); end
    check(!bad, "R7 monitor disabled in stop", bad, 0);
    stopMode = 1'b0; idle(60);
    optCme = 1'b1; bad = 1'b0;
    repeat (600) begin if (sysRst) bad = 1'b1; @(negedge clk); end
    check(!bad, "R7 monitor enabled clock running", bad, 0);
    stopMode = 1'b1;
    countLow(n);
    check(n >= 40 && n <= 400, "R6 stop-mode detection window", n, 200);
    check(rstCause == 2'b01, "R6 clock monitor cause", rstCause, 1);
    waitHold(n);
    check(n == HOLD, "R2 hold after monitor", n, HOLD);
    check(rstCause == 2'b01, "R9 cause kept after release", rstCause, 1);
    stopMode = 1'b0; idle(100);

    // external over monitor
    stopMode = 1'b1; porN = 1'b0;
    idle(400);
    check(sysRst == 1'b1, "R8 R1 external reset asserted", sysRst, 1);
    check(rstCause == 2'b00, "R8 external outranks monitor", rstCause, 0);
    stopMode = 1'b0; idle(100);
    porN = 1'b1;
    waitHold(n);
    check(n == HOLD, "R2 hold after external", n, HOLD);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule